// File: doc/BRIEF.md
# Prioritized Local Store Controller

This block is the private scratchpad of one vector core. Software addresses it directly. It has no tags and no hit or miss logic: an address always selects one physical line. Three clients share one single-port array made of four banks, and the array grants one access per cycle:

- a DMA engine that fills lines from main memory;
- the core's load/store unit;
- its instruction fetch unit.

Each stored 128-bit line carries nine check bits. A single flipped bit is corrected on the way out, and a double flip is reported as uncorrectable.

DMA work enters as descriptors on a command stream. Each descriptor gives a line-aligned local address and a beat count, and the controller holds up to sixteen of them. The descriptor at the head is worked off one 128-bit beat per granted cycle. Its data comes from an inbound data stream, standing in for the main-memory side. All request inputs follow valid/ready rules:

- a requester raises valid with a stable payload and holds both until it sees ready in the same cycle;
- ready is the grant, so it is never high without valid;
- the command stream's ready means only that the queue has room.

Read responses have no back-pressure. They appear a fixed two cycles after the grant, and the requester must take them.

Top module: `lsc_top`

## Requirements
- R1: After reset `rsp_valid`, `dma_done`, `din_ready`, `ls_ready` and `if_ready` are low and `cmd_ready` is high.
- R2: At most one of `din_ready`, `ls_ready`, `if_ready` is high per cycle. A pending DMA beat wins over load/store, which wins over fetch, and each ready is high only while its own valid is high.
- R3: A read granted at a clock edge gives `rsp_valid` high for one cycle after the second following edge. `rsp_to_fetch` is 0 for a load/store read and 1 for a fetch read. A write gives no response.
- R4: Byte address bits [17:16] select one of four banks. The line index is taken from the low log2(BANK_LINES) bits of address [15:4]. Bits [3:0] and index bits above that width are ignored, so such addresses alias.
- R5: A load/store write (`ls_we`=1) stores `ls_wdata`, and any later read of that line returns it.
- R6: A line with any one of its 137 stored bits flipped reads back with its original data, `rsp_corr`=1 and `rsp_uncorr`=0. A clean line reads with both flags 0.
- R7: A line with two distinct stored bits flipped reads with `rsp_uncorr`=1 and `rsp_corr`=0.
- R8: The command queue holds CMD_DEPTH (16) descriptors, counting the one in progress until its last beat is written. `cmd_ready` is low while it is full, and it rises only in the cycle that `dma_done` is high.
- R9: A descriptor writes `cmd_beats_m1`+1 beats. Beat k goes to `cmd_addr`+16·k, modulo 2^18, and may cross into the next bank. Beats take `din_data` in stream order, one per DMA grant. DMA requests only while a descriptor is pending and `din_valid` is high.
- R10: `dma_done` is high for one cycle, in the cycle after the last beat's handshake. Descriptors run in order, and the next one's first beat can be granted in that same cycle.
- R11: The largest descriptor (`cmd_beats_m1`=1023, 16 KB) writes all 1024 beats and gives exactly one `dma_done`, after the final beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | DMA descriptor offered |
| cmd_ready | output | 1 | Queue has room |
| cmd_addr | input | 18 | Local byte address of the first beat |
| cmd_beats_m1 | input | 10 | Beat count minus one |
| din_valid | input | 1 | Inbound DMA beat available |
| din_ready | output | 1 | DMA beat granted and written this cycle |
| din_data | input | 128 | Inbound DMA beat |
| dma_done | output | 1 | Descriptor finished pulse |
| ls_valid | input | 1 | Load/store request |
| ls_ready | output | 1 | Load/store granted |
| ls_we | input | 1 | 1 = write, 0 = read |
| ls_addr | input | 18 | Load/store byte address |
| ls_wdata | input | 128 | Load/store write data |
| if_valid | input | 1 | Fetch read request |
| if_ready | output | 1 | Fetch granted |
| if_addr | input | 18 | Fetch byte address |
| rsp_valid | output | 1 | Read data valid |
| rsp_to_fetch | output | 1 | Response owner: 0 load/store, 1 fetch |
| rsp_data | output | 128 | Corrected read data |
| rsp_corr | output | 1 | Single-bit error was corrected |
| rsp_uncorr | output | 1 | Uncorrectable error detected |

## Verification
The two functions that meet in one cycle are a DMA beat write and a load/store or fetch request: all three requests are raised together while a four-beat descriptor is pending. The bench checks the ready pins cycle by cycle and expects four DMA grants. The load/store grant must then land in the same cycle as the `dma_done` pulse, with fetch granted one cycle after that. The load/store read targets the line the last DMA beat wrote, so its response must carry the freshly written beat, followed one cycle later by the fetch response.

// File: rtl/lsc_pkg.sv
package lsc_pkg;
  localparam int ADDR_W      = 18;
  localparam int LINE_W      = 128;
  localparam int LINE_LSB    = 4;
  localparam int BANK_LSB    = 16;
  localparam int BANK_W      = ADDR_W - BANK_LSB;
  localparam int NBANK       = 1 << BANK_W;
  localparam int XFER_BYTES  = 16384;
  localparam int BEAT_W      = $clog2(XFER_BYTES / (LINE_W / 8));
  localparam int HAM_R       = 8;
  localparam int HAM_N       = LINE_W + HAM_R;
  localparam int CW_W        = HAM_N + 1;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [LINE_W-1:0] line_t;
  typedef logic [CW_W-1:0]   cw_t;

  typedef struct packed {
    addr_t             addr;
    logic [BEAT_W-1:0] beats_m1;
  } dma_cmd_t;

  typedef struct packed {
    line_t data;
    logic  corr;
    logic  uncorr;
  } ecc_res_t;

  // Hamming positions 1..HAM_N, check bits at powers of two, overall parity at bit 0.
  function automatic cw_t ecc_encode(line_t d);
    cw_t c;
    logic [HAM_R-1:0] syn;
    int j;
    c = '0;
    j = 0;
    for (int p = 1; p <= HAM_N; p++) begin
      if ((p & (p - 1)) != 0) begin
        c[p] = d[j];
        j++;
      end
    end
    syn = '0;
    for (int p = 1; p <= HAM_N; p++) begin
      if (c[p]) syn ^= HAM_R'(p);
    end
    for (int i = 0; i < HAM_R; i++) c[1 << i] = syn[i];
    c[0] = ^c[CW_W-1:1];
    return c;
  endfunction

  function automatic ecc_res_t ecc_decode(cw_t cw);
    ecc_res_t r;
    cw_t c;
    logic [HAM_R-1:0] syn;
    logic par;
    int j;
    c   = cw;
    syn = '0;
    for (int p = 1; p <= HAM_N; p++) begin
      if (c[p]) syn ^= HAM_R'(p);
    end
    par      = ^c;
    r.corr   = 1'b0;
    r.uncorr = 1'b0;
    if (par) begin
      if (int'(syn) <= HAM_N) begin
        if (syn != '0) c[syn] = ~c[syn];
        r.corr = 1'b1;
      end else begin
        r.uncorr = 1'b1;
      end
    end else if (syn != '0) begin
      r.uncorr = 1'b1;
    end
    r.data = '0;
    j = 0;
    for (int p = 1; p <= HAM_N; p++) begin
      if ((p & (p - 1)) != 0) begin
        r.data[j] = c[p];
        j++;
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/lsc_prio_arb.sv
module lsc_prio_arb #(
  parameter int N = 3
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt
);
  for (genvar i = 0; i < N; i++) begin : g_lvl
    if (i == 0) begin : g_top
      assign gnt[i] = req[i];
    end else begin : g_low
      assign gnt[i] = req[i] & ~(|req[i-1:0]);
    end
  end
endmodule

// File: rtl/lsc_cmd_fifo.sv
module lsc_cmd_fifo #(
  parameter int W     = 28,
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         empty,
  output logic         full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     slots [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] count;

  assign empty = (count == '0);
  assign full  = (count == CNT_W'(DEPTH));
  assign head  = slots[rd_ptr];

  function automatic logic [PTR_W-1:0] nxt(logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) slots[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= nxt(wr_ptr);
      if (pop)  rd_ptr <= nxt(rd_ptr);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/lsc_dma_seq.sv
module lsc_dma_seq
  import lsc_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  dma_cmd_t head,
  input  logic     beat_fire,
  output addr_t    beat_addr,
  output logic     pop,
  output logic     done
);
  logic [BEAT_W-1:0] beat_cnt;
  logic              last;

  assign beat_addr = head.addr + (ADDR_W'(beat_cnt) << LINE_LSB);
  assign last      = (beat_cnt == head.beats_m1);
  assign pop       = beat_fire && last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      beat_cnt <= '0;
      done     <= 1'b0;
    end else begin
      done <= pop;
      if (beat_fire) beat_cnt <= last ? '0 : beat_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/lsc_bank.sv
module lsc_bank #(
  parameter int LINES = 256,
  parameter int W     = 137
) (
  input  logic                     clk,
  input  logic                     en,
  input  logic                     we,
  input  logic [$clog2(LINES)-1:0] idx,
  input  logic [W-1:0]             wdata,
  output logic [W-1:0]             rdata
);
  logic [W-1:0] mem [LINES];

  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[idx] <= wdata;
      else    rdata    <= mem[idx];
    end
  end
endmodule

// File: rtl/lsc_top.sv
module lsc_top
  import lsc_pkg::*;
#(
  parameter int BANK_LINES = 256,
  parameter int CMD_DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [BEAT_W-1:0] cmd_beats_m1,
  input  logic              din_valid,
  output logic              din_ready,
  input  logic [LINE_W-1:0] din_data,
  output logic              dma_done,
  input  logic              ls_valid,
  output logic              ls_ready,
  input  logic              ls_we,
  input  logic [ADDR_W-1:0] ls_addr,
  input  logic [LINE_W-1:0] ls_wdata,
  input  logic              if_valid,
  output logic              if_ready,
  input  logic [ADDR_W-1:0] if_addr,
  output logic              rsp_valid,
  output logic              rsp_to_fetch,
  output logic [LINE_W-1:0] rsp_data,
  output logic              rsp_corr,
  output logic              rsp_uncorr
);
  localparam int IDX_W = $clog2(BANK_LINES);
  localparam int CMD_W = $bits(dma_cmd_t);
  localparam int G_DMA = 0;
  localparam int G_LS  = 1;
  localparam int G_IF  = 2;

  // command queue and beat sequencer
  dma_cmd_t q_head, q_in;
  logic     q_empty, q_full, q_pop;
  addr_t    dma_addr;

  assign q_in.addr     = cmd_addr;
  assign q_in.beats_m1 = cmd_beats_m1;
  assign cmd_ready     = !q_full;

  lsc_cmd_fifo #(.W(CMD_W), .DEPTH(CMD_DEPTH)) u_q (
    .clk(clk), .rst_n(rst_n),
    .push(cmd_valid && !q_full), .push_data(q_in),
    .pop(q_pop), .head(q_head), .empty(q_empty), .full(q_full)
  );

  // arbitration
  logic [2:0] req, gnt;
  assign req[G_DMA] = din_valid && !q_empty;
  assign req[G_LS]  = ls_valid;
  assign req[G_IF]  = if_valid;

  lsc_prio_arb #(.N(3)) u_arb (.req(req), .gnt(gnt));

  assign din_ready = gnt[G_DMA];
  assign ls_ready  = gnt[G_LS];
  assign if_ready  = gnt[G_IF];

  lsc_dma_seq u_seq (
    .clk(clk), .rst_n(rst_n), .head(q_head), .beat_fire(gnt[G_DMA]),
    .beat_addr(dma_addr), .pop(q_pop), .done(dma_done)
  );

  // access selection
  addr_t             acc_addr;
  logic              acc_we, acc_en;
  line_t             acc_wdata;
  cw_t               acc_cw;
  logic [BANK_W-1:0] acc_bank;
  logic [IDX_W-1:0]  acc_idx;

  always_comb begin
    acc_addr  = if_addr;
    acc_we    = 1'b0;
    acc_wdata = ls_wdata;
    if (gnt[G_DMA]) begin
      acc_addr  = dma_addr;
      acc_we    = 1'b1;
      acc_wdata = din_data;
    end else if (gnt[G_LS]) begin
      acc_addr  = ls_addr;
      acc_we    = ls_we;
    end
  end

  assign acc_en   = |gnt;
  assign acc_bank = acc_addr[BANK_LSB +: BANK_W];
  assign acc_idx  = acc_addr[LINE_LSB +: IDX_W];
  assign acc_cw   = ecc_encode(acc_wdata);

  // banks
  cw_t bank_q [NBANK];
  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    lsc_bank #(.LINES(BANK_LINES), .W(CW_W)) u_bank (
      .clk(clk), .en(acc_en && (acc_bank == BANK_W'(b))), .we(acc_we),
      .idx(acc_idx), .wdata(acc_cw), .rdata(bank_q[b])
    );
  end

  // read pipeline: array stage then check stage
  logic              s1_valid, s1_fetch;
  logic [BANK_W-1:0] s1_bank;
  ecc_res_t          s1_res;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_fetch <= 1'b0;
      s1_bank  <= '0;
    end else begin
      s1_valid <= acc_en && !acc_we;
      s1_fetch <= gnt[G_IF];
      s1_bank  <= acc_bank;
    end
  end

  assign s1_res = ecc_decode(bank_q[s1_bank]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid    <= 1'b0;
      rsp_to_fetch <= 1'b0;
      rsp_corr     <= 1'b0;
      rsp_uncorr   <= 1'b0;
      rsp_data     <= '0;
    end else begin
      rsp_valid  <= s1_valid;
      rsp_corr   <= s1_valid && s1_res.corr;
      rsp_uncorr <= s1_valid && s1_res.uncorr;
      if (s1_valid) begin
        rsp_to_fetch <= s1_fetch;
        rsp_data     <= s1_res.data;
      end
    end
  end

  logic unused_addr_bits;
  assign unused_addr_bits = ^{ls_addr, if_addr, dma_addr};
endmodule

// File: rtl/lsc_top_chk.sv
module lsc_top_chk (
  input logic clk,
  input logic rst_n,
  input logic din_valid,
  input logic din_ready,
  input logic ls_valid,
  input logic ls_ready,
  input logic ls_we,
  input logic if_valid,
  input logic if_ready,
  input logic rsp_valid,
  input logic rsp_corr,
  input logic rsp_uncorr,
  input logic dma_done,
  input logic cmd_ready,
  input logic q_empty
);
  logic rd_hs;
  assign rd_hs = (ls_valid && ls_ready && !ls_we) || (if_valid && if_ready);

  p_onehot_grant_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({din_ready, ls_ready, if_ready}));
  p_ls_ready_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ls_ready |-> ls_valid);
  p_if_ready_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    if_ready |-> if_valid);
  p_dma_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (din_valid && !q_empty) |-> (din_ready && !ls_ready && !if_ready));
  p_ls_over_if_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ls_valid |-> !if_ready);
  p_rsp_follows_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hs |-> ##2 rsp_valid);
  p_rsp_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(rd_hs, 2));
  p_flags_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(rsp_corr && rsp_uncorr));
  p_flags_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> (!rsp_corr && !rsp_uncorr));
  p_ready_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_ready) |-> dma_done);
  p_done_after_beat_r10: assert property (@(posedge clk) disable iff (!rst_n)
    dma_done |-> $past(din_valid && din_ready));
endmodule

bind lsc_top lsc_top_chk u_chk (
  .clk(clk), .rst_n(rst_n), .din_valid(din_valid), .din_ready(din_ready),
  .ls_valid(ls_valid), .ls_ready(ls_ready), .ls_we(ls_we),
  .if_valid(if_valid), .if_ready(if_ready), .rsp_valid(rsp_valid),
  .rsp_corr(rsp_corr), .rsp_uncorr(rsp_uncorr), .dma_done(dma_done),
  .cmd_ready(cmd_ready), .q_empty(q_empty)
);

// File: tb/lsc_top_tb.sv
module lsc_top_tb;
  import lsc_pkg::*;

  localparam int LINES = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 0, din_valid = 0, ls_valid = 0, ls_we = 0, if_valid = 0;
  logic [ADDR_W-1:0] cmd_addr = '0, ls_addr = '0, if_addr = '0;
  logic [BEAT_W-1:0] cmd_beats_m1 = '0;
  line_t din_data = '0, ls_wdata = '0;
  logic cmd_ready, din_ready, dma_done, ls_ready, if_ready;
  logic rsp_valid, rsp_to_fetch, rsp_corr, rsp_uncorr;
  line_t rsp_data;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  lsc_top #(.BANK_LINES(LINES), .CMD_DEPTH(16)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_addr(cmd_addr),
    .cmd_beats_m1(cmd_beats_m1),
    .din_valid(din_valid), .din_ready(din_ready), .din_data(din_data),
    .dma_done(dma_done),
    .ls_valid(ls_valid), .ls_ready(ls_ready), .ls_we(ls_we),
    .ls_addr(ls_addr), .ls_wdata(ls_wdata),
    .if_valid(if_valid), .if_ready(if_ready), .if_addr(if_addr),
    .rsp_valid(rsp_valid), .rsp_to_fetch(rsp_to_fetch), .rsp_data(rsp_data),
    .rsp_corr(rsp_corr), .rsp_uncorr(rsp_uncorr)
  );

  function automatic line_t pat(int k);
    logic [31:0] w;
    w = 32'(k) * 32'h9E3779B1 + 32'h01234567;
    return {w, ~w, w ^ 32'h5A5A5A5A, 32'(k)};
  endfunction

  function automatic addr_t la(int b, int i);
    return ADDR_W'((b << 16) | (i << 4));
  endfunction

  task automatic chk(string tag, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic ls_write(addr_t a, line_t d);
    @(negedge clk);
    ls_valid = 1; ls_we = 1; ls_addr = a; ls_wdata = d;
    #1;
    while (!ls_ready) begin @(negedge clk); #1; end
    @(posedge clk);
    @(negedge clk);
    ls_valid = 0; ls_we = 0;
    chk("R3 write gives no response", rsp_valid, 0);
    @(negedge clk);
    chk("R3 write gives no response", rsp_valid, 0);
  endtask

  task automatic rd_check(bit fetch, addr_t a, line_t exp, bit ec, bit eu, string tag);
    @(negedge clk);
    if (fetch) begin if_valid = 1; if_addr = a; end
    else begin ls_valid = 1; ls_we = 0; ls_addr = a; end
    #1;
    while (!(fetch ? if_ready : ls_ready)) begin @(negedge clk); #1; end
    @(posedge clk);
    @(negedge clk);
    if_valid = 0; ls_valid = 0;
    chk("R3 no early response", rsp_valid, 0);
    @(negedge clk);
    chk("R3 response valid", rsp_valid, 1);
    chk("R3 response owner", rsp_to_fetch, fetch);
    if (!eu) chk(tag, rsp_data, exp);
    chk({tag, " corr flag"}, rsp_corr, ec);
    chk({tag, " uncorr flag"}, rsp_uncorr, eu);
  endtask

  task automatic push_cmd(addr_t a, int m1);
    @(negedge clk);
    cmd_valid = 1; cmd_addr = a; cmd_beats_m1 = BEAT_W'(m1);
    #1;
    while (!cmd_ready) begin @(negedge clk); #1; end
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 0;
  endtask

  task automatic stream(int nbeats, int k0, output int dones, output logic last_done);
    int n;
    n = 0;
    dones = 0;
    while (n < nbeats) begin
      @(negedge clk);
      if (dma_done) dones++;
      din_valid = 1;
      din_data = pat(k0 + n);
      #1;
      if (din_ready) n++;
    end
    @(negedge clk);
    din_valid = 0;
    last_done = dma_done;
    if (dma_done) dones++;
  endtask

  task automatic flip(int b, int i, int bit_a);
    case (b)
      0: u_dut.g_bank[0].u_bank.mem[i] = u_dut.g_bank[0].u_bank.mem[i] ^ (CW_W'(1) << bit_a);
      default: u_dut.g_bank[1].u_bank.mem[i] = u_dut.g_bank[1].u_bank.mem[i] ^ (CW_W'(1) << bit_a);
    endcase
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog act=running exp=finished");
    summary();
  end

  initial begin
    int dn;
    logic ld;
    repeat (5) @(negedge clk);
    rst_n = 1;
    #1;
    chk("R1 rsp_valid", rsp_valid, 0);
    chk("R1 dma_done", dma_done, 0);
    chk("R1 cmd_ready", cmd_ready, 1);
    chk("R1 grants", {din_ready, ls_ready, if_ready}, 0);

    // R5 / R4: fill every line of every bank, then read it all back
    for (int b = 0; b < 4; b++)
      for (int i = 0; i < LINES; i++) ls_write(la(b, i), pat(b * 16 + i));
    for (int b = 0; b < 4; b++)
      for (int i = 0; i < LINES; i++)
        rd_check(i[0], la(b, i), pat(b * 16 + i), 0, 0, "R5 R4 R6 readback");

    // R4: ignored address bits alias onto the same line
    rd_check(0, ADDR_W'((2 << 16) | (12'hAB5 << 4) | 4'hC), pat(37), 0, 0, "R4 alias");
    rd_check(1, ADDR_W'((3 << 16) | (12'h7F0 << 4) | 4'h3), pat(48), 0, 0, "R4 alias");

    // R6: every single-bit flip of one stored word is corrected
    for (int k = 0; k < CW_W; k++) begin
      @(negedge clk); flip(1, 3, k);
      rd_check(k[0], la(1, 3), pat(19), 1, 0, "R6 single flip");
      @(negedge clk); flip(1, 3, k);
    end
    rd_check(0, la(1, 3), pat(19), 0, 0, "R6 restored clean");

    // R7: adjacent double flips, plus the two ends
    for (int k = 0; k < CW_W - 1; k++) begin
      @(negedge clk); flip(0, 7, k); flip(0, 7, k + 1);
      rd_check(k[0], la(0, 7), pat(7), 0, 1, "R7 double flip");
      @(negedge clk); flip(0, 7, k); flip(0, 7, k + 1);
    end
    @(negedge clk); flip(0, 7, 0); flip(0, 7, CW_W - 1);
    rd_check(0, la(0, 7), pat(7), 0, 1, "R7 double flip ends");
    @(negedge clk); flip(0, 7, 0); flip(0, 7, CW_W - 1);

    // R2 / R10: DMA beats, load/store and fetch all requesting together
    push_cmd(la(3, 0), 3);
    @(negedge clk);
    din_valid = 1; din_data = pat(200);
    ls_valid = 1; ls_we = 0; ls_addr = la(3, 3);
    if_valid = 1; if_addr = la(3, 2);
    for (int c = 0; c < 4; c++) begin
      #1;
      chk("R2 DMA wins", {din_ready, ls_ready, if_ready}, 3'b100);
      @(negedge clk);
      din_data = pat(201 + c);
    end
    #1;
    chk("R10 done after last beat", dma_done, 1);
    chk("R2 load/store next", {din_ready, ls_ready, if_ready}, 3'b010);
    @(negedge clk);
    ls_valid = 0;
    #1;
    chk("R10 done one cycle", dma_done, 0);
    chk("R2 fetch last", {din_ready, ls_ready, if_ready}, 3'b001);
    @(negedge clk);
    if_valid = 0; din_valid = 0;
    chk("R3 ls response", {rsp_valid, rsp_to_fetch}, 2'b10);
    chk("R9 ls sees DMA beat 3", rsp_data, pat(203));
    @(negedge clk);
    chk("R3 fetch response", {rsp_valid, rsp_to_fetch}, 2'b11);
    chk("R9 fetch sees DMA beat 2", rsp_data, pat(202));
    rd_check(0, la(3, 0), pat(200), 0, 0, "R9 beat 0");
    rd_check(1, la(3, 4), pat(52), 0, 0, "R9 beyond transfer untouched");

    // R9: transfer crossing from bank 0 into bank 1
    push_cmd(ADDR_W'(18'h0FFF0), 2);
    stream(3, 300, dn, ld);
    chk("R10 one done", dn, 1);
    chk("R10 done at end", ld, 1);
    rd_check(0, la(0, 15), pat(300), 0, 0, "R9 bank0 last line");
    rd_check(1, la(1, 0), pat(301), 0, 0, "R9 crossed into bank1");
    rd_check(0, la(1, 1), pat(302), 0, 0, "R9 bank1 line1");
    rd_check(1, la(0, 14), pat(14), 0, 0, "R9 line before start untouched");

    // R8: fill the queue
    for (int i = 0; i < 16; i++) begin
      chk("R8 room before full", cmd_ready, 1);
      push_cmd(la(2, i), 0);
    end
    #1;
    chk("R8 full after 16", cmd_ready, 0);
    cmd_valid = 1; cmd_addr = la(0, 0); cmd_beats_m1 = 0;
    for (int c = 0; c < 3; c++) begin
      @(negedge clk); #1;
      chk("R8 held off while full", cmd_ready, 0);
    end
    cmd_valid = 0;
    stream(16, 400, dn, ld);
    chk("R10 one done per command", dn, 16);
    chk("R8 room again", cmd_ready, 1);
    @(negedge clk);
    din_valid = 1;
    #1;
    chk("R9 no DMA without command", din_ready, 0);
    @(negedge clk);
    din_valid = 0;
    for (int i = 0; i < 16; i++) rd_check(i[0], la(2, i), pat(400 + i), 0, 0, "R8 queued beats");
    rd_check(0, la(0, 0), pat(0), 0, 0, "R8 refused command not run");

    // R11: largest transfer
    push_cmd(la(2, 0), 1023);
    stream(1024, 1000, dn, ld);
    chk("R11 single done", dn, 1);
    chk("R11 done after final beat", ld, 1);
    for (int i = 0; i < 16; i++) rd_check(i[0], la(2, i), pat(2008 + i), 0, 0, "R11 last lap data");

    summary();
  end
endmodule